// File: doc/BRIEF.md
# Word-Serial Modular Adder-Subtractor

This block computes C = (A + B) mod P or C = (A - B) mod P for multi-word operands. The operands arrive one word per cycle, least significant word first. The modulus is P = 2^(W·N) - 2^H + 1, and its words come from a small constant table indexed by word number. With the defaults W = 32, N = 7 and H = 96, this is a 224-bit generalized Mersenne prime.

Two word-serial chains run in lockstep and never branch:

- **Primary chain.** In add mode it forms S = A + B. In subtract mode it forms S = A - B.
- **Correction chain.** It takes each word of S as that word is produced. In add mode it forms T = S - P. In subtract mode it forms T = S + P.

Each chain keeps its carry or borrow in a register outside its word adder. Both candidate results are shifted into buffers. Once the last operand word has been absorbed, the final carry and borrow flags choose one buffer, and that buffer streams out through a multiplexer.

A caller pulses `start_i` with `sub_i` set to the desired operation. It then presents the N word pairs with `in_valid_i`, and may leave idle cycles between words. It then collects N output words, followed by a one-cycle `done_o`.

Top module: `wsmod_addsub`

## Requirements
- R1: With `sub_i`=0 at start and both operands in [0, P), the N output words (least significant first) equal (A + B) mod P, including wrap to zero when A + B = P.
- R2: With `sub_i`=1 at start and both operands in [0, P), the output words equal (A - B) mod P. A negative difference yields A - B + P.
- R3: Operand words are taken only in cycles with `in_valid_i` high after an accepted start. Idle cycles between words do not change the result. `in_valid_i` with no preceding start produces no output.
- R4: `out_valid_o` rises in the cycle right after the edge that takes the last operand word. It stays high for exactly N consecutive cycles.
- R5: `done_o` is high for exactly one cycle, namely the cycle after the last output word.
- R6: Every start clears both chains' carry/borrow flags, so a flag left by one operation never affects the next.
- R7: During and right after reset, `out_valid_o` and `done_o` are low.
- R8: `start_i` and `in_valid_i` are ignored while a result is being emitted or `done_o` is high. The result stays unchanged, and no extra output follows `done_o`.
- R9: In add mode, when A + B carries out of the top word (A + B ≥ 2^(W·N)), the corrected value A + B - P is emitted even though the correction chain ends with a borrow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation (accepted when idle) |
| sub_i | input | 1 | Operation taken at start: 0 add, 1 subtract |
| in_valid_i | input | 1 | Operand word pair valid |
| a_i | input | W | Word of operand A |
| b_i | input | W | Word of operand B |
| out_valid_o | output | 1 | Result word valid |
| out_word_o | output | W | Result word, least significant first |
| done_o | output | 1 | One-cycle pulse after the last result word |

## Verification
The checker watches the following on every cycle:

- the emission window (it opens only right after an operand word was taken, and lasts exactly N cycles);
- the single-cycle `done_o` that closes that window;
- quiet outputs under reset.

Only the bench's scenarios can show that the emitted words are arithmetically right. It compares them against wide-integer references across several cases:

- zero operands and P - 1;
- sums that carry out of the top word;
- differences that go negative;
- gapped input;
- stray `start_i` and `in_valid_i` while busy;
- back-to-back operations, which show that no stale flag survives.

// File: rtl/wsmod_pkg.sv
package wsmod_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_EMIT = 2'd2,
    ST_FIN  = 2'd3
  } wsmod_state_e;
endpackage

// File: rtl/wsmod_rom.sv
// Modulus word table: P = 2^(W*N) - 2^HOLE + 1, computed bit by bit.
module wsmod_rom #(
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned N_WORDS = 7,
  parameter int unsigned HOLE    = 96,
  localparam int unsigned IDX_W  = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
  input  logic [IDX_W-1:0]  idx_i,
  output logic [WORD_W-1:0] word_o
);
  always_comb begin
    for (int b = 0; b < WORD_W; b++) begin
      int unsigned pos;
      pos = int'(idx_i) * WORD_W + b;
      word_o[b] = (pos >= HOLE) || (pos == 0);
    end
  end
endmodule

// File: rtl/wsmod_chain.sv
// One word adder with its carry/borrow held in an external register.
// flag_q means carry-out when neg_i=0, borrow-out when neg_i=1.
module wsmod_chain #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              en_i,
  input  logic              neg_i,
  input  logic [WORD_W-1:0] x_i,
  input  logic [WORD_W-1:0] y_i,
  output logic [WORD_W-1:0] sum_o,
  output logic              flag_o
);
  logic              flag_q;
  logic [WORD_W:0]   ext;
  logic [WORD_W-1:0] y_eff;

  assign y_eff  = neg_i ? ~y_i : y_i;
  assign ext    = {1'b0, x_i} + {1'b0, y_eff} + {{WORD_W{1'b0}}, flag_q ^ neg_i};
  assign sum_o  = ext[WORD_W-1:0];
  assign flag_o = flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flag_q <= 1'b0;
    else if (clear_i) flag_q <= 1'b0;
    else if (en_i)    flag_q <= ext[WORD_W] ^ neg_i;
  end
endmodule

// File: rtl/wsmod_buf.sv
// Candidate buffer: shift register, word 0 ends at the head.
module wsmod_buf #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned DEPTH  = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic [WORD_W-1:0] din_i,
  output logic [WORD_W-1:0] head_o
);
  logic [WORD_W-1:0] stage_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    logic [WORD_W-1:0] nxt;
    if (g == DEPTH - 1) begin : g_top
      assign nxt = din_i;
    end else begin : g_mid
      assign nxt = stage_q[g+1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      stage_q[g] <= '0;
      else if (shift_i) stage_q[g] <= nxt;
    end
  end

  assign head_o = stage_q[0];
endmodule

// File: rtl/wsmod_ctrl.sv
module wsmod_ctrl
  import wsmod_pkg::*;
#(
  parameter int unsigned N_WORDS = 7,
  localparam int unsigned IDX_W  = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             sub_i,
  input  logic             in_valid_i,
  output logic             clear_o,
  output logic             cap_o,
  output logic             emit_o,
  output logic             done_o,
  output logic             sub_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_WORDS - 1);

  wsmod_state_e     state_q, state_d;
  logic [IDX_W-1:0] cnt_q, cnt_d;
  logic             sub_q;

  assign clear_o = (state_q == ST_IDLE) && start_i;
  assign cap_o   = (state_q == ST_LOAD) && in_valid_i;
  assign emit_o  = (state_q == ST_EMIT);
  assign done_o  = (state_q == ST_FIN);
  assign sub_o   = sub_q;
  assign idx_o   = cnt_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_LOAD;
        cnt_d   = '0;
      end
      ST_LOAD: if (in_valid_i) begin
        cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        if (cnt_q == LAST) state_d = ST_EMIT;
      end
      ST_EMIT: begin
        cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        if (cnt_q == LAST) state_d = ST_FIN;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sub_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      if (clear_o) sub_q <= sub_i;
    end
  end
endmodule

// File: rtl/wsmod_addsub.sv
module wsmod_addsub #(
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned N_WORDS = 7,
  parameter int unsigned HOLE    = 96
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              sub_i,
  input  logic              in_valid_i,
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  output logic              out_valid_o,
  output logic [WORD_W-1:0] out_word_o,
  output logic              done_o
);
  localparam int unsigned IDX_W = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;

  logic              clear, cap, emit, sub_q;
  logic [IDX_W-1:0]  idx;
  logic [WORD_W-1:0] p_word, s_word, t_word, s_head, t_head;
  logic              s_flag, t_flag, pick_t;

  wsmod_ctrl #(.N_WORDS(N_WORDS)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .sub_i, .in_valid_i,
    .clear_o(clear), .cap_o(cap), .emit_o(emit), .done_o,
    .sub_o(sub_q), .idx_o(idx)
  );

  wsmod_rom #(.WORD_W(WORD_W), .N_WORDS(N_WORDS), .HOLE(HOLE)) u_rom (
    .idx_i(idx), .word_o(p_word)
  );

  // Primary chain: A+B or A-B
  wsmod_chain #(.WORD_W(WORD_W)) u_chain_s (
    .clk_i, .rst_ni, .clear_i(clear), .en_i(cap), .neg_i(sub_q),
    .x_i(a_i), .y_i(b_i), .sum_o(s_word), .flag_o(s_flag)
  );

  // Correction chain: S-P or S+P on the same cycle's word
  wsmod_chain #(.WORD_W(WORD_W)) u_chain_t (
    .clk_i, .rst_ni, .clear_i(clear), .en_i(cap), .neg_i(~sub_q),
    .x_i(s_word), .y_i(p_word), .sum_o(t_word), .flag_o(t_flag)
  );

  wsmod_buf #(.WORD_W(WORD_W), .DEPTH(N_WORDS)) u_buf_s (
    .clk_i, .rst_ni, .shift_i(cap | emit), .din_i(s_word), .head_o(s_head)
  );

  wsmod_buf #(.WORD_W(WORD_W), .DEPTH(N_WORDS)) u_buf_t (
    .clk_i, .rst_ni, .shift_i(cap | emit), .din_i(t_word), .head_o(t_head)
  );

  // add: keep S only if T borrowed and S did not carry out; sub: T if S borrowed
  assign pick_t      = sub_q ? s_flag : (s_flag | ~t_flag);
  assign out_valid_o = emit;
  assign out_word_o  = emit ? (pick_t ? t_head : s_head) : '0;
endmodule

// File: rtl/wsmod_addsub_chk.sv
module wsmod_addsub_chk #(
  parameter int unsigned N_WORDS = 7
) (
  input logic clk_i,
  input logic rst_ni,
  input logic in_valid_i,
  input logic out_valid_o,
  input logic done_o
);
  int unsigned run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          run_q <= 0;
    else if (out_valid_o) run_q <= run_q + 1;
    else                  run_q <= 0;
  end

  p_emit_start_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_o) |-> $past(in_valid_i));

  p_emit_len_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (run_q < N_WORDS));

  p_done_len_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (run_q == N_WORDS) && !out_valid_o);

  p_done_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !out_valid_o);

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      p_quiet_reset_r7: assert (!out_valid_o && !done_o);
    end
  end
endmodule

bind wsmod_addsub wsmod_addsub_chk #(.N_WORDS(N_WORDS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i),
  .out_valid_o(out_valid_o), .done_o(done_o)
);

// File: tb/sim_wsmod_addsub.sv
module sim_wsmod_addsub;
  localparam int W = 32;
  localparam int N = 7;
  localparam int BITS = W * N;
  typedef logic [BITS+31:0] wide_t;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic start_i = 1'b0, sub_i = 1'b0, in_valid_i = 1'b0;
  logic [W-1:0] a_i = '0, b_i = '0;
  logic out_valid_o, done_o;
  logic [W-1:0] out_word_o;

  int tests = 0, fails = 0;
  logic [W-1:0] exp_q[$];
  string tag_q[$];
  int run_n = 0;
  wide_t pmod;

  always #2ns clk_i = ~clk_i;

  wsmod_addsub #(.WORD_W(W), .N_WORDS(N), .HOLE(96)) u0 (.*);

  task automatic check(input bit ok, input string req, input logic [W-1:0] act, exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: scoreboard pop on every output word, R4/R5 framing
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (out_valid_o) begin
        if (exp_q.size() == 0) check(1'b0, "R8 unexpected word", out_word_o, '0);
        else begin
          logic [W-1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(out_word_o === e, t, out_word_o, e);
        end
        run_n++;
      end else begin
        if (done_o) check(run_n == N, "R5 done after N words", W'(run_n), W'(N));
        run_n = 0;
      end
    end
  end

  task automatic run_op(input logic [BITS-1:0] a, b, input bit sub,
                        input int gap, input bit poke, input string tag);
    wide_t r;
    if (sub) r = ({32'b0, a} + pmod - {32'b0, b}) % pmod;
    else     r = ({32'b0, a} + {32'b0, b}) % pmod;
    for (int w = 0; w < N; w++) begin
      exp_q.push_back(r[w*W +: W]);
      tag_q.push_back(tag);
    end
    start_i = 1'b1; sub_i = sub;
    @(negedge clk_i);
    start_i = 1'b0; sub_i = ~sub;
    for (int w = 0; w < N; w++) begin
      in_valid_i = 1'b1; a_i = a[w*W +: W]; b_i = b[w*W +: W];
      @(negedge clk_i);
      in_valid_i = 1'b0; a_i = '1; b_i = '1;
      if (w < N - 1) repeat (gap) @(negedge clk_i);
    end
    check(out_valid_o === 1'b1, "R4 output right after last word", W'(out_valid_o), W'(1));
    if (poke) begin
      in_valid_i = 1'b1; start_i = 1'b1;
      while (!done_o) @(negedge clk_i);
      in_valid_i = 1'b0; start_i = 1'b0;
    end else begin
      while (!done_o) @(negedge clk_i);
    end
    @(negedge clk_i);
    check(done_o === 1'b0, "R5 done single cycle", W'(done_o), W'(0));
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [BITS-1:0] pm1, ra, rb;
    pmod = (wide_t'(1) << BITS) - (wide_t'(1) << 96) + wide_t'(1);
    pm1  = BITS'(pmod - 1);
    repeat (3) @(negedge clk_i);
    check(out_valid_o === 1'b0 && done_o === 1'b0, "R7 reset quiet",
          {30'b0, out_valid_o, done_o}, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(out_valid_o === 1'b0 && done_o === 1'b0, "R7 after reset",
          {30'b0, out_valid_o, done_o}, '0);

    // R3: valid without start yields nothing
    in_valid_i = 1'b1; a_i = 32'h1234; b_i = 32'h5678;
    repeat (3 * N) @(negedge clk_i);
    in_valid_i = 1'b0;
    check(out_valid_o === 1'b0, "R3 no start no output", W'(out_valid_o), W'(0));

    run_op(BITS'(5), BITS'(7), 1'b0, 0, 1'b0, "R1 add small");
    run_op('0, '0, 1'b0, 0, 1'b0, "R1 add zero");
    run_op(pm1, BITS'(1), 1'b0, 0, 1'b0, "R1 add wrap to zero");
    run_op(pm1, pm1, 1'b0, 0, 1'b0, "R9 add carry out of top word");
    run_op(BITS'(7), BITS'(5), 1'b1, 0, 1'b0, "R2 sub positive");
    run_op(BITS'(5), BITS'(7), 1'b1, 0, 1'b0, "R2 sub negative wrap");
    run_op('0, pm1, 1'b1, 0, 1'b0, "R2 sub zero minus P-1");
    run_op(pm1, pm1, 1'b1, 0, 1'b0, "R2 sub equal");
    // R6: borrow left by previous op must not leak into this add
    run_op(BITS'(3), BITS'(4), 1'b1, 0, 1'b0, "R6 sub before add");
    run_op(BITS'(3), BITS'(4), 1'b0, 0, 1'b0, "R6 add after borrow");
    run_op(pm1, BITS'(2), 1'b0, 3, 1'b0, "R3 gapped input");
    run_op(pm1, BITS'(9), 1'b1, 2, 1'b1, "R8 pokes while busy");
    repeat (2 * N) @(negedge clk_i);
    check(out_valid_o === 1'b0 && exp_q.size() == 0, "R8 no extra output",
          W'(out_valid_o), W'(0));

    for (int i = 0; i < 40; i++) begin
      for (int w = 0; w < N; w++) begin
        ra[w*W +: W] = $urandom;
        rb[w*W +: W] = $urandom;
      end
      ra = BITS'({32'b0, ra} % pmod);
      rb = BITS'({32'b0, rb} % pmod);
      run_op(ra, rb, i[0], i % 3, i[2], i[0] ? "R2 random sub" : "R1 random add");
    end

    repeat (4) @(negedge clk_i);
    check(exp_q.size() == 0, "R4 all words emitted", W'(exp_q.size()), W'(0));
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule